// File: doc/BRIEF.md
# Variable-Length Instruction Decoder and Target Address Generator

This block takes the leading bytes of one instruction for a 24-bit-word machine with a 1 MB byte address space. It works out how long the instruction is (1 to 4 bytes) and pulls out the opcode, the register nibbles and the six addressing flags. It then forms the 20-bit target address from the displacement, the base register, the program counter and the index register. It also reports whether the operand is immediate, simple or indirect, and it raises an error for flag combinations that have no meaning. It does not fetch any operands or follow indirection.

Instructions arrive on a valid/ready input stream. The result leaves on a valid/ready output stream through a single register stage. The input is accepted in any cycle where the output register is empty or is being drained, so one instruction per cycle goes through when there is no back-pressure. While the output is stalled (out_valid high, out_ready low), the result is held unchanged and in_ready stays low, so any presented instruction waits at the input. `pc_in` is the address of the first byte of the presented instruction.

Top module: `insn_addr_gen`

## Requirements
- R1: Length comes from the first byte (in_bytes[31:24]). Opcodes C0, C4, C8, F0, F4 and F8 give length 1. Opcodes 90, 94, 98, 9C, A0, A4, A8, AC, B0, B4 and B8 give length 2. Any other opcode with flag bit e = 1 (in_bytes[20]) and n/i not both 0 gives length 4. Everything else gives length 3 (for example 4C).
- R2: For lengths 1 and 2, out_opcode is the whole first byte. Otherwise it is that byte with its two low bits cleared. out_r1 is in_bytes[23:20] and out_r2 is in_bytes[19:16] for every format.
- R3: The flag bits are n = in_bytes[25], i = in_bytes[24], x = in_bytes[23], b = in_bytes[22], p = in_bytes[21] and e = in_bytes[20]. out_flags is {n,i,x,b,p,e}. The operand kind comes from n/i: 01 gives out_imm, 10 gives out_ind, and 11 or 00 give out_simple. Lengths 1 and 2 assert no kind, and their out_flags and out_ta are 0.
- R4: When b = p = 0 in a 3-byte instruction, the target is the 12-bit field in_bytes[19:8], zero-extended. When x = 1, index_in is added to the target in every 3- and 4-byte form.
- R5: When b = 0 and p = 1, the target is pc_in + length + the 12-bit field taken as signed two's complement (-2048..2047).
- R6: When b = 1 and p = 0, the target is base_in + the 12-bit field taken as unsigned (0..4095).
- R7: In the 4-byte form, the target is the 20-bit field in_bytes[19:0], plus index_in when x = 1.
- R8: When n = i = 0 (and the opcode is not length 1 or 2), the instruction is 3 bytes long. Its target is the 15-bit field in_bytes[22:8], plus index_in when in_bytes[23] = 1. The b, p and e positions belong to the address, and out_flags reports only x.
- R9: Every address sum wraps modulo 2^20.
- R10: out_err is 1 when b = p = 1 in a 3-byte instruction, or when b or p is 1 in a 4-byte instruction. Otherwise it is 0.
- R11: An instruction is accepted on a rising edge where in_valid and in_ready are both high. Its result appears with out_valid one cycle later. in_ready is high whenever the output register is empty or out_ready is high.
- R12: While out_valid is high and out_ready is low, every output holds its value and no new instruction is accepted.
- R13: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction bytes are valid |
| in_ready | output | 1 | Block accepts an instruction this cycle |
| in_bytes | input | 32 | Instruction bytes, first byte in [31:24] |
| pc_in | input | 20 | Address of the instruction's first byte |
| base_in | input | 20 | Base register value |
| index_in | input | 20 | Index register value |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 3 | Instruction length in bytes |
| out_opcode | output | 8 | Decoded opcode |
| out_r1 | output | 4 | First register nibble |
| out_r2 | output | 4 | Second register nibble |
| out_flags | output | 6 | {n,i,x,b,p,e} |
| out_imm | output | 1 | Operand is immediate |
| out_simple | output | 1 | Operand is simple |
| out_ind | output | 1 | Operand is indirect |
| out_err | output | 1 | Invalid b/p combination |
| out_ta | output | 20 | Target address |

## Verification
Two things can fall in the same cycle: a stalled result being released and a new instruction being loaded behind it. The bench provokes this by holding out_ready low while a second instruction waits on the input, then raising out_ready with the second instruction still presented. It judges that the first result stays unchanged through the stall, that in_ready is low during the stall, and that the second target appears in the very next cycle. Address corner cases are covered in the same flow: PC-relative displacements that wrap below zero and indexed 20-bit addresses that wrap past the top of memory.

// File: rtl/insn_pkg.sv
package insn_pkg;
  localparam int ADDR_W = 20;
  localparam int BYTES_W = 32;

  typedef enum logic [1:0] {TA_ABS, TA_PCREL, TA_BASE, TA_LEGACY} ta_mode_e;

  typedef struct packed {
    logic [2:0]  len;
    logic [7:0]  opcode;
    logic [3:0]  r1;
    logic [3:0]  r2;
    logic [5:0]  flags;
    logic        imm;
    logic        simple;
    logic        ind;
    logic        err;
    logic [ADDR_W-1:0] ta;
  } result_t;

  function automatic logic op_is_one_byte(input logic [7:0] op);
    case (op)
      8'hC0, 8'hC4, 8'hC8, 8'hF0, 8'hF4, 8'hF8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_two_byte(input logic [7:0] op);
    case (op)
      8'h90, 8'h94, 8'h98, 8'h9C, 8'hA0, 8'hA4,
      8'hA8, 8'hAC, 8'hB0, 8'hB4, 8'hB8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/insn_fmt_decode.sv
module insn_fmt_decode
  import insn_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [31:0]   bytes_i,
  output logic [2:0]    len_o,
  output logic [7:0]    opcode_o,
  output logic [3:0]    r1_o,
  output logic [3:0]    r2_o,
  output logic [5:0]    flags_o,
  output logic          imm_o,
  output logic          simple_o,
  output logic          ind_o,
  output logic          err_o,
  output ta_mode_e      mode_o,
  output logic [AW-1:0] field_o,
  output logic          use_x_o
);
  logic [7:0] b0;
  logic one_b, two_b, legacy, long_f;
  logic fn, fi, fx, fb, fp, fe;

  assign b0     = bytes_i[31:24];
  assign fn     = bytes_i[25];
  assign fi     = bytes_i[24];
  assign fx     = bytes_i[23];
  assign fb     = bytes_i[22];
  assign fp     = bytes_i[21];
  assign fe     = bytes_i[20];
  assign one_b  = op_is_one_byte(b0);
  assign two_b  = op_is_two_byte(b0) && !one_b;
  assign legacy = !one_b && !two_b && !fn && !fi;
  assign long_f = !one_b && !two_b && !legacy && fe;
  assign r1_o   = bytes_i[23:20];
  assign r2_o   = bytes_i[19:16];

  always_comb begin
    len_o    = 3'd3;
    opcode_o = {b0[7:2], 2'b00};
    flags_o  = {fn, fi, fx, fb, fp, fe};
    imm_o    = fi && !fn;
    ind_o    = fn && !fi;
    simple_o = fn == fi;
    err_o    = 1'b0;
    mode_o   = TA_ABS;
    field_o  = AW'(bytes_i[19:8]);
    use_x_o  = fx;
    if (one_b || two_b) begin
      len_o    = one_b ? 3'd1 : 3'd2;
      opcode_o = b0;
      flags_o  = '0;
      imm_o    = 1'b0;
      ind_o    = 1'b0;
      simple_o = 1'b0;
      field_o  = '0;
      use_x_o  = 1'b0;
    end else if (legacy) begin
      flags_o = {2'b00, fx, 3'b000};
      mode_o  = TA_LEGACY;
      field_o = AW'(bytes_i[22:8]);
    end else if (long_f) begin
      len_o   = 3'd4;
      err_o   = fb || fp;
      field_o = AW'(bytes_i[19:0]);
    end else begin
      err_o = fb && fp;
      if (fb && !fp) mode_o = TA_BASE;
      else if (fp && !fb) mode_o = TA_PCREL;
    end
  end
endmodule

// File: rtl/insn_ta_calc.sv
module insn_ta_calc
  import insn_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DISPW = 12
) (
  input  ta_mode_e      mode_i,
  input  logic [AW-1:0] field_i,
  input  logic          use_x_i,
  input  logic [2:0]    len_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] ta_o
);
  logic [AW-1:0] anchor, offset, sdisp, xterm;

  assign sdisp = {{(AW-DISPW){field_i[DISPW-1]}}, field_i[DISPW-1:0]};
  assign xterm = use_x_i ? idx_i : '0;

  always_comb begin
    anchor = '0;
    offset = field_i;
    case (mode_i)
      TA_PCREL: begin
        anchor = pc_i + AW'(len_i);
        offset = sdisp;
      end
      TA_BASE: anchor = base_i;
      default: anchor = '0;
    endcase
  end

  assign ta_o = anchor + offset + xterm;
endmodule

// File: rtl/insn_out_stage.sv
module insn_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R11
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/insn_addr_gen.sv
module insn_addr_gen
  import insn_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_bytes,
  input  logic [AW-1:0] pc_in,
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] index_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_len,
  output logic [7:0]    out_opcode,
  output logic [3:0]    out_r1,
  output logic [3:0]    out_r2,
  output logic [5:0]    out_flags,
  output logic          out_imm,
  output logic          out_simple,
  output logic          out_ind,
  output logic          out_err,
  output logic [AW-1:0] out_ta
);
  localparam int RW = $bits(result_t);

  result_t  nxt, cur;
  ta_mode_e mode;
  logic [AW-1:0] field;
  logic use_x;

  insn_fmt_decode #(.AW(AW)) u_dec (
    .bytes_i(in_bytes), .len_o(nxt.len), .opcode_o(nxt.opcode),
    .r1_o(nxt.r1), .r2_o(nxt.r2), .flags_o(nxt.flags),
    .imm_o(nxt.imm), .simple_o(nxt.simple), .ind_o(nxt.ind),
    .err_o(nxt.err), .mode_o(mode), .field_o(field), .use_x_o(use_x)
  );

  insn_ta_calc #(.AW(AW)) u_ta (
    .mode_i(mode), .field_i(field), .use_x_i(use_x), .len_i(nxt.len),
    .pc_i(pc_in), .base_i(base_in), .idx_i(index_in), .ta_o(nxt.ta)
  );

  insn_out_stage #(.W(RW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(nxt), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(cur)
  );

  assign out_len    = cur.len;
  assign out_opcode = cur.opcode;
  assign out_r1     = cur.r1;
  assign out_r2     = cur.r2;
  assign out_flags  = cur.flags;
  assign out_imm    = cur.imm;
  assign out_simple = cur.simple;
  assign out_ind    = cur.ind;
  assign out_err    = cur.err;
  assign out_ta     = cur.ta;

  // R3
  kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_imm, out_simple, out_ind}) &&
                  ((out_len >= 3'd3) == (out_imm || out_simple || out_ind)));

  // R10
  long_bp_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len == 3'd4 && (out_flags[2] || out_flags[1]) |-> out_err);

  // R10
  short_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len < 3'd3 |-> !out_err && out_ta == '0);
endmodule

// File: tb/insn_addr_gen_test.sv
module insn_addr_gen_test;
  typedef struct packed {
    logic [31:0] bytes;
    logic [19:0] pc;
    logic [2:0]  len;
    logic [7:0]  op;
    logic [1:0]  kind;   // 0 none, 1 imm, 2 simple, 3 indirect
    logic [19:0] ta;
    logic        err;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'hC4000000, 20'h01000, 3'd1, 8'hC4, 2'd0, 20'h00000, 1'b0}, // R1 one byte
    '{32'hA0040000, 20'h01000, 3'd2, 8'hA0, 2'd0, 20'h00000, 1'b0}, // R1 R2 two byte
    '{32'h4F000000, 20'h01000, 3'd3, 8'h4C, 2'd2, 20'h00000, 1'b0}, // R1 three byte
    '{32'h01000300, 20'h01000, 3'd3, 8'h00, 2'd1, 20'h00003, 1'b0}, // R3 R4 immediate
    '{32'h17202D00, 20'h00000, 3'd3, 8'h14, 2'd2, 20'h00030, 1'b0}, // R5 pc rel
    '{32'h032FFE00, 20'h01000, 3'd3, 8'h00, 2'd2, 20'h01001, 1'b0}, // R5 negative
    '{32'h03280000, 20'h00000, 3'd3, 8'h00, 2'd2, 20'hFF803, 1'b0}, // R9 wrap
    '{32'h034FFF00, 20'h01000, 3'd3, 8'h00, 2'd2, 20'h011FF, 1'b0}, // R6 base max
    '{32'h03C01000, 20'h01000, 3'd3, 8'h00, 2'd2, 20'h00220, 1'b0}, // R6 base + index
    '{32'h02812300, 20'h01000, 3'd3, 8'h00, 2'd3, 20'h00133, 1'b0}, // R3 R4 indirect
    '{32'h03600000, 20'h01000, 3'd3, 8'h00, 2'd2, 20'h00000, 1'b1}, // R10 b and p
    '{32'h4B101036, 20'h01000, 3'd4, 8'h48, 2'd2, 20'h01036, 1'b0}, // R7 long
    '{32'h039FFFFF, 20'h01000, 3'd4, 8'h00, 2'd2, 20'h0000F, 1'b0}, // R7 R9 long wrap
    '{32'h03300000, 20'h01000, 3'd4, 8'h00, 2'd2, 20'h00000, 1'b1}, // R10 long p
    '{32'h00900000, 20'h01000, 3'd3, 8'h00, 2'd2, 20'h01010, 1'b0}, // R8 legacy
    '{32'h00F00000, 20'h01000, 3'd3, 8'h00, 2'd2, 20'h07010, 1'b0}  // R8 legacy high bits
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [31:0] in_bytes = '0;
  logic [19:0] pc_in = '0, base_in = 20'h00200, index_in = 20'h00010;
  logic in_ready, out_valid, out_imm, out_simple, out_ind, out_err;
  logic [2:0] out_len;
  logic [7:0] out_opcode;
  logic [3:0] out_r1, out_r2;
  logic [5:0] out_flags;
  logic [19:0] out_ta;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  insn_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .pc_in(pc_in), .base_in(base_in), .index_in(index_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
    .out_opcode(out_opcode), .out_r1(out_r1), .out_r2(out_r2),
    .out_flags(out_flags), .out_imm(out_imm), .out_simple(out_simple),
    .out_ind(out_ind), .out_err(out_err), .out_ta(out_ta)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] kind_of();
    return out_imm ? 2'd1 : out_simple ? 2'd2 : out_ind ? 2'd3 : 2'd0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R13 out_valid after reset", 32'(out_valid), 0);
    check("R13 in_ready after reset", 32'(in_ready), 1);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_bytes = VECS[k].bytes; pc_in = VECS[k].pc;
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 out_valid", 32'(out_valid), 1);
      check("R1 length", 32'(out_len), 32'(VECS[k].len));
      check("R2 opcode", 32'(out_opcode), 32'(VECS[k].op));
      check("R2 register nibbles", {24'h0, out_r1, out_r2}, {24'h0, VECS[k].bytes[23:16]});
      check("R3 operand kind", 32'(kind_of()), 32'(VECS[k].kind));
      check("R10 error", 32'(out_err), 32'(VECS[k].err));
      if (!VECS[k].err)
        check("R4 R5 R6 R7 R8 R9 target", 32'(out_ta), 32'(VECS[k].ta));
    end

    // R3: flags zero for short forms, legacy reports only x (R8)
    @(negedge clk); in_valid = 1'b1; in_bytes = 32'hA0FF0000;
    @(negedge clk); in_valid = 1'b0;
    check("R3 short form flags", 32'(out_flags), 0);
    @(negedge clk); in_valid = 1'b1; in_bytes = 32'h00F00000;
    @(negedge clk); in_valid = 1'b0;
    check("R8 legacy flags", 32'(out_flags), 32'h08);

    // R11 R12: stall with a second instruction waiting, then release
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_bytes = 32'h4B101036; pc_in = 20'h01000;
    @(negedge clk);
    in_bytes = 32'h01000300;
    check("R12 valid during stall", 32'(out_valid), 1);
    check("R11 in_ready low during stall", 32'(in_ready), 0);
    check("R12 first target shown", 32'(out_ta), 32'h01036);
    @(negedge clk);
    check("R12 target held", 32'(out_ta), 32'h01036);
    check("R12 length held", 32'(out_len), 4);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second loaded on release", 32'(out_ta), 32'h00003);
    check("R11 second kind", 32'(kind_of()), 1);
    @(negedge clk);
    check("R11 drained", 32'(out_valid), 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule